// File: doc/BRIEF.md
# Protected-Register Unlock and Initialization Handshake Controller

This controller sits in front of the configuration registers of a real-time clock. Software can only change those registers after it writes two fixed key values, in the right order, to a dedicated key register. Any other write to the key register closes the gate again. While the gate is open, the block drives a write-enable to the protected registers. It also accepts writes to its own control register and to the two writable status bits.

The block also runs two handshakes that cross from the bus clock into the slower RTC kernel clock. The RTC kernel clock is seen here as a one-cycle `rtc_tick` strobe that is already synchronised to `clk`. The first handshake is initialization mode: software sets a request bit, and a separate grant flag follows it a fixed number of ticks later. The grant flag is what freezes the prescaler and calendar. The second handshake is the shadow-resync flag. Software clears it by writing 0. Hardware sets it again a fixed number of ticks after the shadow time and date are refreshed, and also after initialization mode ends. A calendar-initialized bit reports whether the calendar year is non-zero.

Register map (word index on `bus_addr`): 0 = status, 1 = control, 2 = key. Status byte layout: bit 7 = init request, bit 6 = init granted, bit 5 = resync done, bit 4 = calendar set. All other status bits read 0, and the key register reads 0.

Top module: `rtc_guard_ctrl`

## Requirements
- R1: A write of 0xCA to the key register followed by a write of 0x53 to the key register raises `prot_wr_en` from the cycle after the second write.
- R2: Any key-register write while unlocked relocks at once. A wrong value after 0xCA also returns to locked, so a later 0x53 alone does not unlock.
- R3: While locked, writes to the control register and to status bits 7 and 5 are dropped.
- R4: After bit 7 of the status register is set, status bit 6 and `init_active` rise on exactly the SYNC_TICKS-th `rtc_tick`. Before that tick they stay low.
- R5: After bit 7 is cleared, status bit 6 and `init_active` fall on exactly the SYNC_TICKS-th `rtc_tick`.
- R6: An unlocked status write with bit 5 = 0 clears the resync flag. An unlocked status write with bit 5 = 1 leaves the flag unchanged.
- R7: The resync flag (status bit 5) sets on the SYNC_TICKS-th `rtc_tick` after a `shadow_upd` pulse. It also sets on the SYNC_TICKS-th tick after `init_active` falls.
- R8: Status bit 4 reads 1 when `year_nonzero` is 1, and 0 otherwise.
- R9: After reset the block is locked, init mode is off, and the resync flag, the init request and the control register are 0.
- R10: An unlocked write to the control register is read back unchanged and appears on `ctrl_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register |
| rtc_tick | input | 1 | One-cycle strobe per RTC kernel clock, synchronised to `clk` |
| shadow_upd | input | 1 | Pulse when the shadow time and date are refreshed |
| year_nonzero | input | 1 | High when the calendar year field is not zero |
| prot_wr_en | output | 1 | Write-enable to the protected registers |
| init_active | output | 1 | Initialization granted; freezes the prescaler and calendar |
| ctrl_q | output | CTRL_W | Control register contents |
| stat_flags | output | 8 | Status byte |

## Verification
The key gate is tried with the correct pair of values, with a wrong second value, and with a repeated first value. These patterns tell a true two-step sequence apart from a detector that only looks at the last write. Writes with the gate closed and open show that the write-enable really gates both the control register and the status bits. For both handshakes, the outputs are sampled one tick before and on the SYNC_TICKS-th tick, which exposes any off-by-one in the tick counting. The resync flag is set in two ways: by a shadow refresh and by leaving initialization mode. It is also written with bit 5 = 1 and bit 5 = 0, to separate the clear-by-zero behaviour from plain storage.

// File: rtl/rtc_guard_pkg.sv
package rtc_guard_pkg;
   typedef enum logic [1:0] {
      LK_LOCKED = 2'd0,
      LK_HALF   = 2'd1,
      LK_OPEN   = 2'd2
   } lock_state_t;

   localparam int REG_STATUS   = 0;
   localparam int REG_CTRL     = 1;
   localparam int REG_KEY      = 2;

   localparam int BIT_INIT_REQ = 7;
   localparam int BIT_INIT_ACK = 6;
   localparam int BIT_RESYNC   = 5;
   localparam int BIT_CAL_SET  = 4;
endpackage

// File: rtl/rtc_key_fsm.sv
module rtc_key_fsm
   import rtc_guard_pkg::*;
#(
   parameter int              DATA_W     = 32,
   parameter int              KEY_W      = 8,
   parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hCA,
   parameter logic [KEY_W-1:0] KEY_SECOND = 8'h53
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr,
   input  logic [DATA_W-1:0] key_data,
   output logic              unlocked
);
   localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY_FIRST);
   localparam logic [DATA_W-1:0] K2 = DATA_W'(KEY_SECOND);

   generate
      if (KEY_FIRST == KEY_SECOND) begin : g_bad_keys
         $error("rtc_key_fsm: the two keys must differ");
      end
      if (KEY_W > DATA_W) begin : g_bad_width
         $error("rtc_key_fsm: key wider than data bus");
      end
   endgenerate

   lock_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (key_wr) begin
         case (state_q)
            LK_LOCKED: state_d = (key_data == K1) ? LK_HALF : LK_LOCKED;
            LK_HALF:   state_d = (key_data == K2) ? LK_OPEN : LK_LOCKED;
            default:   state_d = LK_LOCKED;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LK_LOCKED;
      else        state_q <= state_d;
   end

   assign unlocked = (state_q == LK_OPEN);

   AST_OPEN_AFTER_SECOND_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(key_wr && key_data == K2)); // R1
   AST_OPEN_WRITE_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && key_wr) |=> !unlocked); // R2
endmodule

// File: rtl/rtc_tick_follow.sv
module rtc_tick_follow #(
   parameter int SYNC_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic target,
   output logic q
);
   generate
      if (SYNC_TICKS < 1) begin : g_bad
         $error("rtc_tick_follow: SYNC_TICKS must be at least 1");
      end

      if (SYNC_TICKS == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= 1'b0;
            else if (tick)   q <= target;
         end
      end else begin : g_count
         localparam int CNT_W = $clog2(SYNC_TICKS);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_TICKS - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q     <= 1'b0;
               cnt_q <= '0;
            end else if (q == target) begin
               cnt_q <= '0;
            end else if (tick) begin
               if (cnt_q == LAST) begin
                  q     <= target;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end
   endgenerate

   AST_ACK_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(q) |-> $past(tick)); // R4
   AST_ACK_TOWARD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(q) |-> (q == $past(target))); // R5
endmodule

// File: rtl/rtc_resync_timer.sv
module rtc_resync_timer #(
   parameter int SYNC_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic arm,
   output logic done
);
   localparam int CNT_W = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_TICKS - 1);

   generate
      if (SYNC_TICKS < 1) begin : g_bad
         $error("rtc_resync_timer: SYNC_TICKS must be at least 1");
      end
   endgenerate

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   assign done = busy_q && tick && !arm && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (arm) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q && tick) begin
         if (cnt_q == LAST) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   AST_DONE_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy_q); // R7
endmodule

// File: rtl/rtc_guard_ctrl.sv
module rtc_guard_ctrl
   import rtc_guard_pkg::*;
#(
   parameter int ADDR_W     = 2,
   parameter int DATA_W     = 32,
   parameter int CTRL_W     = 8,
   parameter int SYNC_TICKS = 2,
   parameter logic [7:0] KEY_FIRST  = 8'hCA,
   parameter logic [7:0] KEY_SECOND = 8'h53
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rtc_tick,
   input  logic              shadow_upd,
   input  logic              year_nonzero,
   output logic              prot_wr_en,
   output logic              init_active,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [7:0]        stat_flags
);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_KEY    = ADDR_W'(REG_KEY);

   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("rtc_guard_ctrl: DATA_W must hold the status byte");
      end
      if (CTRL_W > DATA_W || CTRL_W < 1) begin : g_bad_ctrl
         $error("rtc_guard_ctrl: CTRL_W out of range");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("rtc_guard_ctrl: ADDR_W too small for three registers");
      end
   endgenerate

   logic wr_key, wr_stat, wr_ctrl;
   logic req_q, ack, ack_prev_q, rsf_q, rsf_done, exit_pulse;

   assign wr_key  = bus_wr && (bus_addr == A_KEY);
   assign wr_stat = bus_wr && (bus_addr == A_STATUS) && prot_wr_en;
   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL)   && prot_wr_en;

   rtc_key_fsm #(
      .DATA_W(DATA_W), .KEY_W(8),
      .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
   ) i_key (
      .clk(clk), .rst_n(rst_n),
      .key_wr(wr_key), .key_data(bus_wdata),
      .unlocked(prot_wr_en)
   );

   rtc_tick_follow #(.SYNC_TICKS(SYNC_TICKS)) i_init_ack (
      .clk(clk), .rst_n(rst_n), .tick(rtc_tick),
      .target(req_q), .q(ack)
   );

   assign exit_pulse = ack_prev_q && !ack;

   rtc_resync_timer #(.SYNC_TICKS(SYNC_TICKS)) i_resync (
      .clk(clk), .rst_n(rst_n), .tick(rtc_tick),
      .arm(shadow_upd || exit_pulse), .done(rsf_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q      <= 1'b0;
         rsf_q      <= 1'b0;
         ack_prev_q <= 1'b0;
         ctrl_q     <= '0;
      end else begin
         ack_prev_q <= ack;
         if (wr_stat) req_q <= bus_wdata[BIT_INIT_REQ];
         if (rsf_done)
            rsf_q <= 1'b1;
         else if (wr_stat && !bus_wdata[BIT_RESYNC])
            rsf_q <= 1'b0;
         if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      end
   end

   assign init_active = ack;

   always_comb begin
      stat_flags               = '0;
      stat_flags[BIT_INIT_REQ] = req_q;
      stat_flags[BIT_INIT_ACK] = ack;
      stat_flags[BIT_RESYNC]   = rsf_q;
      stat_flags[BIT_CAL_SET]  = year_nonzero;
   end

   always_comb begin
      case (bus_addr)
         A_STATUS: bus_rdata = DATA_W'(stat_flags);
         A_CTRL:   bus_rdata = DATA_W'(ctrl_q);
         default:  bus_rdata = '0;
      endcase
   end

   AST_LOCKED_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !prot_wr_en |=> $stable(ctrl_q)); // R3
   AST_LOCKED_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !prot_wr_en |=> $stable(req_q)); // R3
   AST_RSF_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rsf_q) |-> $past(prot_wr_en && bus_wr && bus_addr == A_STATUS)); // R6
   AST_RSF_SET_BY_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsf_q) |-> $past(rsf_done)); // R7
endmodule

// File: tb/test_rtc_guard_ctrl.sv
module test_rtc_guard_ctrl;
   localparam int N = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rtc_tick = 1'b0;
   logic        shadow_upd = 1'b0;
   logic        year_nonzero = 1'b0;
   logic        prot_wr_en, init_active;
   logic [7:0]  ctrl_q, stat_flags;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   int          q_sel[$];
   logic [31:0] q_exp[$];
   string       q_tag[$];

   always #2.5 clk = ~clk;

   rtc_guard_ctrl #(.SYNC_TICKS(N)) i_rtc_guard_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rtc_tick(rtc_tick),
      .shadow_upd(shadow_upd), .year_nonzero(year_nonzero),
      .prot_wr_en(prot_wr_en), .init_active(init_active),
      .ctrl_q(ctrl_q), .stat_flags(stat_flags)
   );

   // monitor: sel 0 = bus_rdata, 1 = prot_wr_en, 2 = init_active, 3 = ctrl_q
   always @(negedge clk) begin
      while (q_sel.size() > 0) begin
         automatic int          s = q_sel.pop_front();
         automatic logic [31:0] e = q_exp.pop_front();
         automatic string       t = q_tag.pop_front();
         automatic logic [31:0] a;
         case (s)
            0:       a = bus_rdata;
            1:       a = {31'd0, prot_wr_en};
            2:       a = {31'd0, init_active};
            default: a = {24'd0, ctrl_q};
         endcase
         checks++;
         if (a !== e) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", t, a, e);
         end
      end
   end

   task automatic expect_item(input int sel, input logic [31:0] exp, input string tag);
      q_sel.push_back(sel);
      q_exp.push_back(exp);
      q_tag.push_back(tag);
      @(negedge clk);
      #1;
   endtask

   task automatic expect_rd(input logic [1:0] addr, input logic [31:0] exp, input string tag);
      bus_addr = addr;
      expect_item(0, exp, tag);
   endtask

   task automatic bus_write(input logic [1:0] addr, input logic [31:0] data);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic tick_once();
      @(posedge clk); #1;
      rtc_tick = 1'b1;
      @(posedge clk); #1;
      rtc_tick = 1'b0;
      @(posedge clk); #1;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick_once();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R9 reset state
      expect_item(1, 0, "R9 locked after reset");
      expect_item(2, 0, "R9 init off after reset");
      expect_rd(2'd0, 32'h00, "R9 status clear after reset");
      expect_rd(2'd1, 32'h00, "R9 ctrl clear after reset");

      // R3 locked writes dropped
      bus_write(2'd1, 32'h5A);
      expect_rd(2'd1, 32'h00, "R3 ctrl write while locked");
      bus_write(2'd0, 32'h80);
      ticks(N);
      expect_rd(2'd0, 32'h00, "R3 init request while locked");

      // R2 wrong second value / repeated first key
      bus_write(2'd2, 32'hCA);
      bus_write(2'd2, 32'h11);
      bus_write(2'd2, 32'h53);
      expect_item(1, 0, "R2 wrong second key");
      bus_write(2'd2, 32'hCA);
      bus_write(2'd2, 32'hCA);
      bus_write(2'd2, 32'h53);
      expect_item(1, 0, "R2 repeated first key");

      // R1 correct pair
      bus_write(2'd2, 32'hCA);
      expect_item(1, 0, "R1 half sequence stays locked");
      bus_write(2'd2, 32'h53);
      expect_item(1, 1, "R1 unlock after key pair");

      // R10 control readback
      bus_write(2'd1, 32'hA5);
      expect_rd(2'd1, 32'hA5, "R10 ctrl readback");
      expect_item(3, 32'hA5, "R10 ctrl_q port");

      // R4 init grant
      bus_write(2'd0, 32'h80);
      ticks(N - 1);
      expect_item(2, 0, "R4 grant not before last tick");
      expect_rd(2'd0, 32'h80, "R4 request only");
      tick_once();
      expect_item(2, 1, "R4 grant on last tick");
      expect_rd(2'd0, 32'hC0, "R4 status request and grant");

      // R5 leave init, R7 resync after exit
      bus_write(2'd0, 32'h00);
      ticks(N - 1);
      expect_item(2, 1, "R5 grant held before last tick");
      tick_once();
      expect_item(2, 0, "R5 grant dropped");
      ticks(N - 1);
      expect_rd(2'd0, 32'h00, "R7 resync not yet after exit");
      tick_once();
      expect_rd(2'd0, 32'h20, "R7 resync after init exit");

      // R6 clear by zero only
      bus_write(2'd0, 32'h20);
      expect_rd(2'd0, 32'h20, "R6 write one keeps flag");
      bus_write(2'd0, 32'h00);
      expect_rd(2'd0, 32'h00, "R6 write zero clears flag");

      // R7 shadow refresh
      @(posedge clk); #1 shadow_upd = 1'b1;
      @(posedge clk); #1 shadow_upd = 1'b0;
      ticks(N - 1);
      expect_rd(2'd0, 32'h00, "R7 resync not yet after refresh");
      tick_once();
      expect_rd(2'd0, 32'h20, "R7 resync after refresh");

      // R8 calendar set flag
      year_nonzero = 1'b1;
      expect_rd(2'd0, 32'h30, "R8 calendar set high");

      // R2 relock then R3 dropped writes
      bus_write(2'd2, 32'hFF);
      expect_item(1, 0, "R2 relock on key write");
      bus_write(2'd1, 32'h00);
      expect_rd(2'd1, 32'hA5, "R3 ctrl held after relock");
      bus_write(2'd0, 32'h00);
      expect_rd(2'd0, 32'h30, "R3 resync held after relock");

      year_nonzero = 1'b0;
      expect_rd(2'd0, 32'h20, "R8 calendar set low");

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule